// File: doc/BRIEF.md
# Two-Level Rotating Bus Arbiter

This block decides which of several bus masters may own a shared parallel bus next. Each master has an active-low request line and receives an active-low grant line. The masters fall into two tiers. The upper tier rotates in round-robin order. The lower tier as a whole fills one extra position in that rotation, and each time that position comes up, exactly one lower-tier master is served, chosen by a second round-robin pointer of its own. As a result, every upper-tier master gets a turn for each single turn given to one lower-tier master.

The arbiter watches the two bus activity strobes (frame and initiator-ready, both active low) to tell whether the bus is idle. It issues a new grant only on an idle bus with no grant outstanding. It withdraws a grant when the owner stops requesting on an idle bus, or when the owner has started using the bus and some other master is waiting. Between two owners there is always at least one clock with no grant asserted.

Top module: `duo_rr_arbiter`

## Requirements
- R1: While reset is asserted and on the first clock after it, every grant output is high (deasserted). Both rotation pointers start at index 0, so with every master requesting, the first grant goes to upper-tier master 0, and the first lower-tier grant goes to lower-tier master 0.
- R2: A request bit at 0 means requesting and a grant bit at 0 means granted. Bit i of each vector belongs to master i of that tier. At most one grant bit across both vectors is 0 at any time.
- R3: With no grant outstanding and the bus idle, a master whose request is sampled low at a rising edge has its grant low after that same edge.
- R4: The bus counts as idle only when frame_n and irdy_n are both high. No new grant is issued while either is low.
- R5: Upper-tier turns go in ascending index order, wrapping around. The lower-tier position follows the last upper-tier master. The rotation resumes after the most recently granted position.
- R6: In each lower-tier position, exactly one lower-tier master is granted, in ascending wrapping order. With two upper-tier and three lower-tier masters all requesting, the order is U0 U1 L0 U0 U1 L1 U0 U1 L2.
- R7: When the lower-tier position comes up and no lower-tier master is requesting, it is skipped in the same evaluation, and the next requesting upper-tier master is granted.
- R8: Upper-tier masters that are not requesting are skipped in the same evaluation.
- R9: On an idle bus, the owner keeps its grant while it still requests. If it raises its request, its grant goes high after the next edge.
- R10: While the bus is busy, the owner keeps its grant if no other master requests. If another master requests, the owner's grant goes high after the next edge.
- R11: A grant never moves directly from one master to another. At least one clock with all grants high separates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_n | input | N_UP | Upper-tier requests, active low |
| lo_req_n | input | N_LO | Lower-tier requests, active low |
| frame_n | input | 1 | Bus frame strobe, active low (low = transaction in progress) |
| irdy_n | input | 1 | Bus initiator-ready strobe, active low |
| up_gnt_n | output | N_UP | Upper-tier grants, active low |
| lo_gnt_n | output | N_LO | Lower-tier grants, active low |

## Verification
A wrong rotation pointer does not show until the next grant is issued. It then appears as the wrong grant bit going low one clock after the bus becomes idle with no grant outstanding. The full nine-turn sequence with all masters requesting is therefore needed to expose a lower-tier pointer that advances too often or too seldom. A faulty hold or drop decision shows within one clock, either as a grant that stays low when it should go high, or as a grant that changes hands with no empty clock between owners. The directed vectors place each such decision under both bus states.

// File: rtl/duo_pkg.sv
package duo_pkg;

   // Wrapping increment used by every rotation pointer.
   function automatic int unsigned next_slot(int unsigned cur, int unsigned n);
      return (cur + 1 >= n) ? 0 : cur + 1;
   endfunction

endpackage

// File: rtl/duo_rr_pick.sv
// Round-robin search: first requesting index at or after ptr, wrapping.
module duo_rr_pick #(
   parameter int N = 3,
   parameter int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] req,
   input  logic [W-1:0] ptr,
   output logic         hit,
   output logic [W-1:0] idx
);
   generate
      if (N == 1) begin : g_single
         assign hit = req[0];
         assign idx = '0;
      end else begin : g_search
         always_comb begin
            hit = 1'b0;
            idx = ptr;
            for (int k = 0; k < N; k++) begin
               if (!hit && req[(int'(ptr) + k) % N]) begin
                  hit = 1'b1;
                  idx = W'((int'(ptr) + k) % N);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/duo_tenure.sv
// Holds the current grant and decides when it is kept, dropped or issued.
module duo_tenure #(
   parameter int NT = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NT-1:0] req,
   input  logic          bus_idle,
   input  logic          win_valid,
   input  logic [NT-1:0] win,
   output logic [NT-1:0] gnt_q,
   output logic          issue
);
   logic          holder_any, holder_req, others;
   logic [NT-1:0] gnt_d;

   assign holder_any = |gnt_q;
   assign holder_req = |(gnt_q & req);
   assign others     = |(req & ~gnt_q);

   always_comb begin
      gnt_d = gnt_q;
      issue = 1'b0;
      if (holder_any) begin
         if (bus_idle ? !holder_req : others) gnt_d = '0;
      end else if (bus_idle && win_valid) begin
         gnt_d = win;
         issue = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gnt_q <= '0;
      else        gnt_q <= gnt_d;
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_q)); // R2
   AST_DEAD_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt_q && $past(|gnt_q)) |-> (gnt_q == $past(gnt_q))); // R11
   AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|gnt_q) |-> $past(bus_idle)); // R4
   AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|gnt_q) |-> |(gnt_q & $past(req))); // R3
   AST_HOLD_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt_q && !bus_idle && !others) |=> (gnt_q == $past(gnt_q))); // R10
   AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt_q && bus_idle && !holder_req) |=> !(|gnt_q)); // R9
endmodule

// File: rtl/duo_rr_arbiter.sv
module duo_rr_arbiter #(
   parameter int N_UP = 2,
   parameter int N_LO = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_UP-1:0] up_req_n,
   input  logic [N_LO-1:0] lo_req_n,
   input  logic            frame_n,
   input  logic            irdy_n,
   output logic [N_UP-1:0] up_gnt_n,
   output logic [N_LO-1:0] lo_gnt_n
);
   localparam int NT = N_UP + N_LO;
   localparam int S1 = N_UP + 1;          // upper slots plus the shared lower slot
   localparam int W1 = $clog2(S1);
   localparam int W2 = (N_LO > 1) ? $clog2(N_LO) : 1;

   generate
      if (N_UP < 1) begin : g_bad_up
         $error("N_UP must be at least 1");
      end
      if (N_LO < 1) begin : g_bad_lo
         $error("N_LO must be at least 1");
      end
   endgenerate

   logic [N_UP-1:0] up_req;
   logic [N_LO-1:0] lo_req;
   logic [S1-1:0]   slot_req;
   logic [W1-1:0]   p1_q, up_idx;
   logic [W2-1:0]   p2_q, lo_idx;
   logic            up_hit, lo_hit, bus_idle, issue;
   logic [NT-1:0]   win, gnt_q;

   assign up_req   = ~up_req_n;
   assign lo_req   = ~lo_req_n;
   assign slot_req = {|lo_req, up_req};
   assign bus_idle = frame_n & irdy_n;

   duo_rr_pick #(.N(S1), .W(W1)) u_pick_up (
      .req(slot_req), .ptr(p1_q), .hit(up_hit), .idx(up_idx));

   duo_rr_pick #(.N(N_LO), .W(W2)) u_pick_lo (
      .req(lo_req), .ptr(p2_q), .hit(lo_hit), .idx(lo_idx));

   // One-hot winner over the flat grant vector: upper tier low, lower tier high.
   always_comb begin
      win = '0;
      for (int m = 0; m < N_UP; m++)
         if (up_idx == W1'(m)) win[m] = 1'b1;
      if (up_idx == W1'(N_UP))
         for (int m = 0; m < N_LO; m++)
            if (lo_idx == W2'(m)) win[N_UP + m] = 1'b1;
   end

   duo_tenure #(.NT(NT)) u_tenure (
      .clk(clk), .rst_n(rst_n), .req({lo_req, up_req}), .bus_idle(bus_idle),
      .win_valid(up_hit), .win(win), .gnt_q(gnt_q), .issue(issue));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p1_q <= '0;
         p2_q <= '0;
      end else if (issue) begin
         p1_q <= W1'(duo_pkg::next_slot(int'(up_idx), S1));
         if (up_idx == W1'(N_UP))
            p2_q <= W2'(duo_pkg::next_slot(int'(lo_idx), N_LO));
      end
   end

   assign up_gnt_n = ~gnt_q[N_UP-1:0];
   assign lo_gnt_n = ~gnt_q[NT-1:N_UP];

   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(p1_q) <= N_UP) && (int'(p2_q) < N_LO)); // R5
   AST_SLOT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (up_hit && up_idx == W1'(N_UP)) |-> lo_hit); // R6
   AST_LO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(issue) && $past(up_idx) != W1'(N_UP)) |-> $stable(p2_q)); // R6
endmodule

// File: tb/duo_rr_arbiter_test.sv
`timescale 1ns/1ps
module duo_rr_arbiter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] up_req_n = 2'b11;
   logic [2:0] lo_req_n = 3'b111;
   logic       frame_n = 1'b1;
   logic       irdy_n = 1'b1;
   logic [1:0] up_gnt_n;
   logic [2:0] lo_gnt_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   duo_rr_arbiter #(.N_UP(2), .N_LO(3)) uut (
      .clk(clk), .rst_n(rst_n), .up_req_n(up_req_n), .lo_req_n(lo_req_n),
      .frame_n(frame_n), .irdy_n(irdy_n), .up_gnt_n(up_gnt_n), .lo_gnt_n(lo_gnt_n));

   // {up_req_n, lo_req_n, frame_n, irdy_n, exp up_gnt_n, exp lo_gnt_n}
   localparam logic [11:0] VEC [19] = '{
      12'b11_111_1_1_11_111,  //  0 R2 nobody requests
      12'b11_101_1_1_11_101,  //  1 R3 lone L1 granted next edge
      12'b11_101_0_1_11_101,  //  2 R10 busy, alone: keep
      12'b10_101_0_1_11_111,  //  3 R10 busy, U0 waits: drop
      12'b10_101_1_1_10_111,  //  4 R11 after dead clock, U0
      12'b11_101_1_1_11_111,  //  5 R9 U0 withdraws on idle bus
      12'b11_101_1_1_11_101,  //  6 R6 lower pointer past L1 wraps back to L1
      12'b11_101_1_1_11_101,  //  7 R9 idle and requesting: keep
      12'b01_111_1_1_11_111,  //  8 R9 L1 withdraws
      12'b01_111_1_1_01_111,  //  9 R8 U0 idle, skipped
      12'b11_110_1_1_11_111,  // 10 R9 U1 withdraws
      12'b11_110_1_1_11_110,  // 11 R6 lower pointer at L2 wraps to L0
      12'b00_111_1_1_11_111,  // 12 R9 L0 withdraws
      12'b00_111_1_1_10_111,  // 13 R5 U0
      12'b00_111_1_0_11_111,  // 14 R4 irdy busy with waiter: drop
      12'b00_111_1_0_11_111,  // 15 R4 still busy: no new grant
      12'b00_111_1_1_01_111,  // 16 R5 U1
      12'b00_111_0_1_11_111,  // 17 R10 frame busy: drop
      12'b00_111_1_1_10_111   // 18 R7 lower slot skipped, U0
   };

   function automatic string row_tag(int r);
      case (r)
         0: return "R2";   1: return "R3";   2: return "R10";  3: return "R10";
         4: return "R11";  5: return "R9";   6: return "R6";   7: return "R9";
         8: return "R9";   9: return "R8";   10: return "R9";  11: return "R6";
         12: return "R9";  13: return "R5";  14: return "R4";  15: return "R4";
         16: return "R5";  17: return "R10"; default: return "R7";
      endcase
   endfunction

   task automatic check(string tag, logic [1:0] e_up, logic [2:0] e_lo);
      checks++;
      if (up_gnt_n !== e_up || lo_gnt_n !== e_lo) begin
         errors++;
         $display("FAIL %s: up_gnt_n=%b lo_gnt_n=%b expected up_gnt_n=%b lo_gnt_n=%b",
                  tag, up_gnt_n, lo_gnt_n, e_up, e_lo);
      end
   endtask

   task automatic do_reset(logic [1:0] ur, logic [2:0] lr);
      rst_n = 1'b0;
      up_req_n = ur;
      lo_req_n = lr;
      frame_n = 1'b1;
      irdy_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 during reset", 2'b11, 3'b111);
      rst_n = 1'b1;
   endtask

   localparam int ORDER [9] = '{0, 1, 2, 0, 1, 3, 0, 1, 4};

   initial begin
      // R6 / R1 / R5: full rotation with everyone requesting.
      do_reset(2'b00, 3'b000);
      for (int t = 0; t < 9; t++) begin
         logic [4:0] exp_n;
         @(negedge clk);
         exp_n = ~(5'b1 << ORDER[t]);
         check((t == 0) ? "R1 first grant U0" : "R6 rotation turn", exp_n[1:0], exp_n[4:2]);
         frame_n = 1'b0;             // owner starts, others waiting
         @(negedge clk);
         check("R11 empty clock", 2'b11, 3'b111);
         frame_n = 1'b1;
      end

      // Table walk from a fresh reset.
      do_reset(2'b11, 3'b111);
      for (int r = 0; r < 19; r++) begin
         {up_req_n, lo_req_n, frame_n, irdy_n} = VEC[r][11:5];
         @(negedge clk);
         check(row_tag(r), VEC[r][4:3], VEC[r][2:0]);
      end

      // R3: lone upper requester after reset, granted one edge later.
      do_reset(2'b11, 3'b111);
      @(negedge clk);
      up_req_n = 2'b01;
      check("R3 before edge", 2'b11, 3'b111);
      @(negedge clk);
      check("R3 after edge", 2'b01, 3'b111);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule